// File: doc/BRIEF.md
# Byte/Word Data Space Access Unit

This unit sits between a 16-bit processor core and a data RAM built as two byte-wide lanes that share a single word address. Every effective address it receives is a 16-bit byte address, so the space spans 64 Kbytes, or 32K words. A general load/store port carries both byte and word operations. The unit steers bytes between the lanes and gates each lane's write enable. It also returns the register-indirect pointer advanced by the access size.

A second path serves multiply-accumulate class instructions. It makes two word fetches in the same cycle: X through RAM port A and Y through RAM port B. Each fetch must use its own pair of pointer registers and must fall inside its own implemented region. The region bounds are module parameters.

An access to an unimplemented address never reaches the RAM as a write. A read from such an address returns zero. In either case the unit raises a one-cycle address-error trap. The trap is aligned with the read data, one cycle after the request, because the RAM has a one-cycle read latency.

Top module: `dspace_unit`

## Requirements
- R1: After reset, `x_valid`, `y_valid` and `addr_trap` are low.
- R2: A load/store word read drives `ram_a_addr` with EA bits 15:1 and ignores EA bit 0. One cycle later `x_valid` is high and `x_rdata` holds the whole word.
- R3: A byte read places the selected byte in `x_rdata[7:0]` one cycle later, with `x_rdata[15:8]` zero. EA bit 0 = 0 selects RAM bits 7:0, and EA bit 0 = 1 selects RAM bits 15:8.
- R4: A byte write copies `ls_wdata[7:0]` onto both lanes of `ram_a_wdata`. It raises only the lane enable that matches EA bit 0: 0 raises `ram_a_we_lo` and 1 raises `ram_a_we_hi`. A word write raises both enables and passes `ls_wdata` unchanged.
- R5: With `ls_inc` high, `ls_ptr_next` is `ls_ptr`+1 for a byte access and `ls_ptr`+2 for a word access. With `ls_inc` low it equals `ls_ptr`. A MAC fetch with its increment flag high advances that pointer by 2.
- R6: A MAC fetch reads Y as a whole word from `ram_b_addr` = Y pointer bits 15:1. One cycle later `y_valid` is high and `y_rdata` holds the word. The X fetch returns a whole word on `x_rdata` in the same cycle.
- R7: The X fetch must name pointer register 10 or 11, and the Y fetch register 8 or 9. Any other register number makes that fetch unimplemented.
- R8: A load/store access is implemented only if its EA lies in [X_LO, X_HI] or [Y_LO, Y_HI]. Otherwise a read returns 0x0000 with `x_valid` high, and `addr_trap` is high in the next cycle.
- R9: A write to an unimplemented address keeps both lane enables low and raises `addr_trap` in the next cycle.
- R10: A MAC X fetch outside [X_LO, X_HI], or a Y fetch outside [Y_LO, Y_HI], returns zero on its own path only and raises `addr_trap`. The other path is unaffected.
- R11: When `mac_req` and `ls_req` are high together, the MAC fetch wins. The load/store operation writes nothing, reads nothing and leaves `ls_ptr_next` equal to `ls_ptr`.
- R12: `addr_trap` is a single-cycle pulse per failing request cycle. X and Y failing together give one pulse, and it is low again after a following good or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ls_req | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store is a write |
| ls_byte | input | 1 | Byte-sized access |
| ls_inc | input | 1 | Post-increment the pointer |
| ls_ptr | input | 16 | Load/store pointer value (byte EA) |
| ls_wdata | input | 16 | Write data (byte in bits 7:0) |
| ls_ptr_next | output | 16 | Advanced load/store pointer |
| mac_req | input | 1 | MAC dual fetch request |
| mac_x_reg | input | 4 | Register number of the X pointer |
| mac_x_ptr | input | 16 | X pointer value |
| mac_x_inc | input | 1 | Post-increment the X pointer |
| mac_y_reg | input | 4 | Register number of the Y pointer |
| mac_y_ptr | input | 16 | Y pointer value |
| mac_y_inc | input | 1 | Post-increment the Y pointer |
| mac_x_ptr_next | output | 16 | Advanced X pointer |
| mac_y_ptr_next | output | 16 | Advanced Y pointer |
| ram_a_addr | output | 15 | Port A word index |
| ram_a_we_lo | output | 1 | Port A low-lane write enable |
| ram_a_we_hi | output | 1 | Port A high-lane write enable |
| ram_a_wdata | output | 16 | Port A write data |
| ram_a_rdata | input | 16 | Port A read data, one cycle after address |
| ram_b_addr | output | 15 | Port B (Y) word index |
| ram_b_rdata | input | 16 | Port B read data, one cycle after address |
| x_valid | output | 1 | X path read result valid |
| x_rdata | output | 16 | X path read result |
| y_valid | output | 1 | Y path read result valid |
| y_rdata | output | 16 | Y path read result |
| addr_trap | output | 1 | Address-error trap pulse |

## Verification
Two functions can fall in the same cycle: a MAC dual fetch and a competing load/store request. The bench provokes this by raising `ls_req` with a write alongside `mac_req`. It judges the collision at the ports: no lane enable may rise, the load/store pointer must stay put, and the X result must come from the MAC pointer. A second collision, an X and a Y region fault in the same fetch, is driven directly. It must produce zero on both paths and exactly one trap cycle, followed by a clear cycle.

// File: rtl/dspace_unit.sv
module dspace_unit #(
  parameter logic [15:0] X_LO = 16'h0800,
  parameter logic [15:0] X_HI = 16'h17FF,
  parameter logic [15:0] Y_LO = 16'h1800,
  parameter logic [15:0] Y_HI = 16'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ls_req,
  input  logic        ls_we,
  input  logic        ls_byte,
  input  logic        ls_inc,
  input  logic [15:0] ls_ptr,
  input  logic [15:0] ls_wdata,
  output logic [15:0] ls_ptr_next,
  input  logic        mac_req,
  input  logic [3:0]  mac_x_reg,
  input  logic [15:0] mac_x_ptr,
  input  logic        mac_x_inc,
  input  logic [3:0]  mac_y_reg,
  input  logic [15:0] mac_y_ptr,
  input  logic        mac_y_inc,
  output logic [15:0] mac_x_ptr_next,
  output logic [15:0] mac_y_ptr_next,
  output logic [14:0] ram_a_addr,
  output logic        ram_a_we_lo,
  output logic        ram_a_we_hi,
  output logic [15:0] ram_a_wdata,
  input  logic [15:0] ram_a_rdata,
  output logic [14:0] ram_b_addr,
  input  logic [15:0] ram_b_rdata,
  output logic        x_valid,
  output logic [15:0] x_rdata,
  output logic        y_valid,
  output logic [15:0] y_rdata,
  output logic        addr_trap
);
  localparam logic [3:0] XR0 = 4'd10;
  localparam logic [3:0] YR0 = 4'd8;

  function automatic logic in_rng(input logic [15:0] a, input logic [15:0] lo, input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic ls_go, ls_ok, x_ok, y_ok, wr_go;
  logic [1:0] ls_step;
  logic xv_q, xb_q, xh_q, xe_q, yv_q, ye_q, trap_q;

  assign ls_go = ls_req && !mac_req;
  assign ls_ok = in_rng(ls_ptr, X_LO, X_HI) || in_rng(ls_ptr, Y_LO, Y_HI);
  assign x_ok  = (mac_x_reg[3:1] == XR0[3:1]) && in_rng(mac_x_ptr, X_LO, X_HI);
  assign y_ok  = (mac_y_reg[3:1] == YR0[3:1]) && in_rng(mac_y_ptr, Y_LO, Y_HI);
  assign wr_go = ls_go && ls_we && ls_ok;

  assign ram_a_addr  = mac_req ? mac_x_ptr[15:1] : ls_ptr[15:1];
  assign ram_b_addr  = mac_y_ptr[15:1];
  assign ram_a_wdata = ls_byte ? {2{ls_wdata[7:0]}} : ls_wdata;
  assign ram_a_we_lo = wr_go && (!ls_byte || !ls_ptr[0]);
  assign ram_a_we_hi = wr_go && (!ls_byte ||  ls_ptr[0]);

  assign ls_step        = (ls_go && ls_inc) ? (ls_byte ? 2'd1 : 2'd2) : 2'd0;
  assign ls_ptr_next    = ls_ptr + {14'd0, ls_step};
  assign mac_x_ptr_next = mac_x_ptr + ((mac_req && mac_x_inc) ? 16'd2 : 16'd0);
  assign mac_y_ptr_next = mac_y_ptr + ((mac_req && mac_y_inc) ? 16'd2 : 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xv_q <= 1'b0; xb_q <= 1'b0; xh_q <= 1'b0; xe_q <= 1'b0;
      yv_q <= 1'b0; ye_q <= 1'b0; trap_q <= 1'b0;
    end else begin
      xv_q   <= mac_req || (ls_go && !ls_we);
      xb_q   <= !mac_req && ls_byte;
      xh_q   <= ls_ptr[0];
      xe_q   <= mac_req ? !x_ok : !ls_ok;
      yv_q   <= mac_req;
      ye_q   <= !y_ok;
      trap_q <= (mac_req && (!x_ok || !y_ok)) || (ls_go && !ls_ok);
    end
  end

  assign x_valid   = xv_q;
  assign x_rdata   = (!xv_q || xe_q) ? 16'h0000 :
                     xb_q ? {8'h00, (xh_q ? ram_a_rdata[15:8] : ram_a_rdata[7:0])} :
                     ram_a_rdata;
  assign y_valid   = yv_q;
  assign y_rdata   = (!yv_q || ye_q) ? 16'h0000 : ram_b_rdata;
  assign addr_trap = trap_q;
endmodule

// File: rtl/dspace_unit_chk.sv
module dspace_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ls_req,
  input logic        ls_we,
  input logic        ls_byte,
  input logic        ls_inc,
  input logic [15:0] ls_ptr,
  input logic [15:0] ls_ptr_next,
  input logic        mac_req,
  input logic [3:0]  mac_y_reg,
  input logic        ram_a_we_lo,
  input logic        ram_a_we_hi,
  input logic        x_valid,
  input logic [15:0] x_rdata,
  input logic        y_valid,
  input logic [15:0] y_rdata,
  input logic        addr_trap
);
  assert_byte_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && !mac_req && ls_we && ls_byte) |-> !(ram_a_we_lo && ram_a_we_hi));

  assert_word_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_req && !mac_req && ls_inc && !ls_byte) |-> (ls_ptr_next == ls_ptr + 16'd2));

  assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && $past(ls_req && !ls_we && ls_byte && !mac_req)) |-> (x_rdata[15:8] == 8'h00));

  assert_y_from_mac_R6: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> $past(mac_req));

  assert_bad_yreg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req && !(mac_y_reg == 4'd8 || mac_y_reg == 4'd9)) |=> (addr_trap && y_rdata == 16'h0000));

  assert_mac_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req |-> (!ram_a_we_lo && !ram_a_we_hi && ls_ptr_next == ls_ptr));
endmodule

bind dspace_unit dspace_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ls_req(ls_req), .ls_we(ls_we), .ls_byte(ls_byte),
  .ls_inc(ls_inc), .ls_ptr(ls_ptr), .ls_ptr_next(ls_ptr_next), .mac_req(mac_req),
  .mac_y_reg(mac_y_reg), .ram_a_we_lo(ram_a_we_lo), .ram_a_we_hi(ram_a_we_hi),
  .x_valid(x_valid), .x_rdata(x_rdata), .y_valid(y_valid), .y_rdata(y_rdata),
  .addr_trap(addr_trap)
);

// File: tb/tb_dspace_unit.sv
`timescale 1ns/1ps
module tb_dspace_unit;
  localparam logic [15:0] XL = 16'h0800, XH = 16'h17FF, YL = 16'h1800, YH = 16'h1FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ls_req = 0, ls_we = 0, ls_byte = 0, ls_inc = 0;
  logic [15:0] ls_ptr = 0, ls_wdata = 0, ls_ptr_next;
  logic mac_req = 0, mac_x_inc = 0, mac_y_inc = 0;
  logic [3:0] mac_x_reg = 0, mac_y_reg = 0;
  logic [15:0] mac_x_ptr = 0, mac_y_ptr = 0, mac_x_ptr_next, mac_y_ptr_next;
  logic [14:0] ram_a_addr, ram_b_addr;
  logic ram_a_we_lo, ram_a_we_hi;
  logic [15:0] ram_a_wdata, ram_a_rdata, ram_b_rdata;
  logic x_valid, y_valid, addr_trap;
  logic [15:0] x_rdata, y_rdata;

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [0:4095];
  logic [15:0] shadow [0:4095];

  always #10 clk = ~clk;

  dspace_unit #(.X_LO(XL), .X_HI(XH), .Y_LO(YL), .Y_HI(YH)) dut (.*);

  always @(posedge clk) begin
    if (ram_a_we_lo) mem[ram_a_addr[11:0]][7:0]  <= ram_a_wdata[7:0];
    if (ram_a_we_hi) mem[ram_a_addr[11:0]][15:8] <= ram_a_wdata[15:8];
    ram_a_rdata <= mem[ram_a_addr[11:0]];
    ram_b_rdata <= mem[ram_b_addr[11:0]];
  end

  function automatic bit in_x(input logic [15:0] a); return a >= XL && a <= XH; endfunction
  function automatic bit in_y(input logic [15:0] a); return a >= YL && a <= YH; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic ls_op(input bit we, input bit byt, input bit inc, input logic [15:0] p, input logic [15:0] wd);
    bit ok;
    logic [15:0] w, ex;
    ok = in_x(p) || in_y(p);
    ls_req = 1; ls_we = we; ls_byte = byt; ls_inc = inc; ls_ptr = p; ls_wdata = wd; mac_req = 0;
    #2;
    chk(ls_ptr_next == p + (inc ? (byt ? 16'd1 : 16'd2) : 16'd0), "R5 ls_ptr_next", ls_ptr_next, p + (inc ? (byt ? 16'd1 : 16'd2) : 16'd0));
    chk(ram_a_addr == p[15:1], "R2 word index", ram_a_addr, p[15:1]);
    if (we) begin
      if (!ok) chk(!ram_a_we_lo && !ram_a_we_hi, "R9 enables low", {ram_a_we_hi, ram_a_we_lo}, 0);
      else if (byt) chk({ram_a_we_hi, ram_a_we_lo} == (p[0] ? 2'b10 : 2'b01) && ram_a_wdata == {2{wd[7:0]}},
                        "R4 byte lane", {ram_a_we_hi, ram_a_we_lo, ram_a_wdata}, {(p[0] ? 2'b10 : 2'b01), wd[7:0], wd[7:0]});
      else chk(ram_a_we_lo && ram_a_we_hi && ram_a_wdata == wd, "R4 word write", {ram_a_we_hi, ram_a_we_lo, ram_a_wdata}, {2'b11, wd});
    end
    w = shadow[p[12:1]];
    ex = !ok ? 16'h0 : byt ? {8'h00, (p[0] ? w[15:8] : w[7:0])} : w;
    if (we && ok) begin
      if (!byt || !p[0]) shadow[p[12:1]][7:0]  = byt ? wd[7:0] : wd[7:0];
      if (!byt ||  p[0]) shadow[p[12:1]][15:8] = byt ? wd[7:0] : wd[15:8];
    end
    @(negedge clk);
    ls_req = 0;
    chk(addr_trap == !ok, ok ? "R8 no trap" : "R8/R9 trap", addr_trap, !ok);
    if (!we) chk(x_valid && x_rdata == ex, byt ? "R3 byte read" : (ok ? "R2 word read" : "R8 zero read"), {x_valid, x_rdata}, {1'b1, ex});
    else chk(!x_valid, "R4 write no valid", x_valid, 0);
  endtask

  task automatic mac_op(input logic [3:0] xr, input logic [15:0] xp, input bit xi,
                        input logic [3:0] yr, input logic [15:0] yp, input bit yi, input bit clash);
    bit xok, yok;
    logic [15:0] ex, ey, lp;
    xok = (xr == 4'd10 || xr == 4'd11) && in_x(xp);
    yok = (yr == 4'd8 || yr == 4'd9) && in_y(yp);
    ex = xok ? shadow[xp[12:1]] : 16'h0;
    ey = yok ? shadow[yp[12:1]] : 16'h0;
    lp = 16'h0900;
    mac_req = 1; mac_x_reg = xr; mac_x_ptr = xp; mac_x_inc = xi; mac_y_reg = yr; mac_y_ptr = yp; mac_y_inc = yi;
    ls_req = clash; ls_we = 1; ls_byte = 0; ls_inc = 1; ls_ptr = lp; ls_wdata = 16'hDEAD;
    #2;
    chk(mac_x_ptr_next == xp + (xi ? 16'd2 : 16'd0) && mac_y_ptr_next == yp + (yi ? 16'd2 : 16'd0),
        "R5 mac step", {mac_x_ptr_next, mac_y_ptr_next}, {xp + (xi ? 16'd2 : 16'd0), yp + (yi ? 16'd2 : 16'd0)});
    chk(ram_b_addr == yp[15:1], "R6 y index", ram_b_addr, yp[15:1]);
    if (clash) chk(!ram_a_we_lo && !ram_a_we_hi && ls_ptr_next == lp, "R11 mac wins",
                   {ram_a_we_hi, ram_a_we_lo, ls_ptr_next}, {2'b00, lp});
    @(negedge clk);
    mac_req = 0; ls_req = 0;
    chk(x_valid && x_rdata == ex, xok ? "R6 x word" : "R7/R10 x zero", {x_valid, x_rdata}, {1'b1, ex});
    chk(y_valid && y_rdata == ey, yok ? "R6 y word" : "R7/R10 y zero", {y_valid, y_rdata}, {1'b1, ey});
    chk(addr_trap == !(xok && yok), "R10/R12 trap", addr_trap, !(xok && yok));
    if (clash) chk(shadow[lp[12:1]] == mem[lp[12:1]], "R11 no write", mem[lp[12:1]], shadow[lp[12:1]]);
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    chk(!addr_trap && !x_valid && !y_valid, req, {addr_trap, x_valid, y_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 16'(i * 16'h9E37 + 16'h1234);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!x_valid && !y_valid && !addr_trap, "R1 reset", {x_valid, y_valid, addr_trap}, 0);
    rst_n = 1;
    @(negedge clk);
    ls_op(0, 0, 1, 16'h0A11, 0);
    ls_op(0, 1, 1, 16'h0A10, 0);
    ls_op(0, 1, 1, 16'h0A11, 0);
    ls_op(1, 1, 0, 16'h0C01, 16'h00A5);
    ls_op(0, 0, 0, 16'h0C00, 0);
    ls_op(1, 0, 1, 16'h1FFF, 16'hBEEF);
    ls_op(0, 0, 0, 16'h1FFE, 0);
    ls_op(0, 0, 1, 16'h07FF, 0);
    idle_chk("R12 trap clears");
    ls_op(1, 0, 0, 16'h2000, 16'h1111);
    mac_op(4'd10, 16'h0800, 1, 4'd8, 16'h1800, 1, 0);
    mac_op(4'd11, 16'h17FE, 0, 4'd9, 16'h1FFE, 1, 1);
    mac_op(4'd12, 16'h0900, 1, 4'd8, 16'h1802, 0, 0);
    mac_op(4'd10, 16'h0900, 1, 4'd7, 16'h1802, 0, 0);
    mac_op(4'd10, 16'h1800, 1, 4'd9, 16'h0800, 1, 1);
    idle_chk("R12 single pulse");
    for (int k = 0; k < 600; k++) begin
      if ($urandom % 3 == 0)
        mac_op(4'(8 + $urandom % 5), 16'($urandom % 16'h2400), 1'($urandom), 4'(7 + $urandom % 4),
               16'($urandom % 16'h2400), 1'($urandom), 1'($urandom));
      else
        ls_op(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom % 16'h2400), 16'($urandom));
    end
    idle_chk("R12 final clear");
    report();
  end
endmodule